// File: doc/BRIEF.md
# Exception Return Integrity Checker

This block sits between the return logic of a small microcontroller-class core and its unstacking sequence. When a handler branches to a magic return value, the core presents that value together with the exception number now being serviced, the bitmap of active exceptions, the exception-number field taken from the stacked status word, and whether the processor is in handler mode. One cycle later the block answers with exactly one of three outcomes. The return is either accepted, faulted as an invalid-PC usage fault, or passed through as an ordinary branch.

On acceptance the block states whether execution resumes in handler or thread mode and on which stack. It also supplies the active bitmap with the returning exception removed. On a fault the bitmap is handed back untouched and a sticky invalid-PC flag is set. Software clears that flag by writing a one. A fault handler that repairs the stacked field or supplies a proper return value can retry, and the retried return is judged afresh.

The block is built around a four-state response machine. `ST_IDLE` means there is no response. `ST_ACCEPT`, `ST_FAULT` and `ST_BRANCH` each last one cycle. Every state is entered from any state on the edge that samples a request. A request made in handler mode goes to `ST_ACCEPT` if it passes every rule and to `ST_FAULT` otherwise. A request made in thread mode goes to `ST_BRANCH`. With no request the machine goes to `ST_IDLE`.

Top module: `exc_ret_check`

## Requirements
- R1: In handler mode, 0xFFFFFFF1 returns to handler mode on the main stack (`tgt_handler`=1, `tgt_psp`=0). 0xFFFFFFF9 returns to thread mode on the main stack (both 0). 0xFFFFFFFD returns to thread mode on the process stack (`tgt_handler`=0, `tgt_psp`=1). These values hold only when the remaining rules pass.
- R2: In handler mode, every other return value faults, including the reserved 0xFFFFFFF0.
- R3: A return faults when the active bit of `cur_excnum` is clear. A `cur_excnum` of `NEXC` or more counts as clear.
- R4: A thread-mode return faults while any active bit other than that of `cur_excnum` is set.
- R5: A thread-mode return faults when `stacked_excnum` is nonzero.
- R6: A handler-mode return faults when `stacked_excnum` is zero.
- R7: On accept, `next_active` equals `active_map` with bit `cur_excnum` cleared. On fault or branch, it equals `active_map` unchanged.
- R8: A request made with `in_handler`=0 gives `rsp_branch`, applies none of the rules, and leaves the sticky flag alone.
- R9: `invpc_sticky` rises on the same edge that produces `rsp_fault` and stays set. A cycle with `sticky_clr`=1 clears it, unless a fault is being recorded on that edge, in which case the fault wins.
- R10: Each request produces exactly one of `rsp_accept`, `rsp_fault` and `rsp_branch`, in the cycle after the request, for one cycle. Without a request all three are 0, and `next_active`, `tgt_handler` and `tgt_psp` are 0.
- R11: After a fault, a retry with the corrected stacked field or return value is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Return request this cycle |
| in_handler | input | 1 | Processor is in handler mode |
| ret_value | input | 32 | Return value taken from the link register |
| cur_excnum | input | EXC_W | Exception number currently being serviced |
| active_map | input | NEXC | Active exception bitmap |
| stacked_excnum | input | EXC_W | Exception-number field of the stacked status word |
| sticky_clr | input | 1 | Write-one-to-clear strobe for the sticky flag |
| rsp_accept | output | 1 | Return is legal |
| rsp_fault | output | 1 | Invalid-PC usage fault |
| rsp_branch | output | 1 | Request passed on as an ordinary branch |
| tgt_handler | output | 1 | Resume in handler mode (on accept) |
| tgt_psp | output | 1 | Resume on the process stack (on accept) |
| next_active | output | NEXC | Updated active bitmap |
| invpc_sticky | output | 1 | Sticky invalid-PC status flag |

## Verification
The bench targets several corner cases that a plain decoder would miss. A reserved code that is one bit away from a legal one must fault, or a sloppy decoder would accept it. A nested exception left active under a thread-mode return must be caught, or the core would resume thread mode with work still pending. Stacked fields that disagree with the requested mode must fault, and an exception number beyond the bitmap must not alias onto a real bit. Retries after each kind of fault must be accepted, and a design that kept the fault state latched would reject them. The sticky flag is checked against a clear strobe that arrives together with a new fault, where the wrong priority would lose the event.

// File: rtl/exc_ret_pkg.sv
package exc_ret_pkg;

    typedef enum logic [1:0] {
        RK_HANDLER_MAIN,
        RK_THREAD_MAIN,
        RK_THREAD_PROC,
        RK_RESERVED
    } ret_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACCEPT,
        ST_FAULT,
        ST_BRANCH
    } resp_state_e;

    localparam logic [31:0] MAGIC_HANDLER_MAIN = 32'hFFFF_FFF1;
    localparam logic [31:0] MAGIC_THREAD_MAIN  = 32'hFFFF_FFF9;
    localparam logic [31:0] MAGIC_THREAD_PROC  = 32'hFFFF_FFFD;

endpackage

// File: rtl/exc_ret_decode.sv
module exc_ret_decode
    import exc_ret_pkg::*;
(
    input  logic [31:0] ret_value,
    output ret_kind_e   kind
);
    always_comb begin
        unique case (ret_value)
            MAGIC_HANDLER_MAIN: kind = RK_HANDLER_MAIN;
            MAGIC_THREAD_MAIN:  kind = RK_THREAD_MAIN;
            MAGIC_THREAD_PROC:  kind = RK_THREAD_PROC;
            default:            kind = RK_RESERVED;
        endcase
    end
endmodule

// File: rtl/exc_ret_rules.sv
module exc_ret_rules
    import exc_ret_pkg::*;
#(
    parameter int NEXC  = 32,
    parameter int EXC_W = 9
) (
    input  ret_kind_e          kind,
    input  logic [EXC_W-1:0]   cur_excnum,
    input  logic [NEXC-1:0]    active_map,
    input  logic [EXC_W-1:0]   stacked_excnum,
    output logic               legal,
    output logic [NEXC-1:0]    cleared_map
);
    logic [NEXC-1:0] own_sel;

    // One-hot select of the returning exception; numbers past NEXC select nothing.
    for (genvar i = 0; i < NEXC; i++) begin : g_sel
        assign own_sel[i] = (cur_excnum == EXC_W'(i));
    end

    logic own_active;
    logic nested_left;
    logic stk_zero;

    assign cleared_map = active_map & ~own_sel;
    assign own_active  = |(active_map & own_sel);
    assign nested_left = |cleared_map;
    assign stk_zero    = (stacked_excnum == '0);

    always_comb begin
        unique case (kind)
            RK_HANDLER_MAIN: legal = own_active && !stk_zero;
            RK_THREAD_MAIN,
            RK_THREAD_PROC:  legal = own_active && !nested_left && stk_zero;
            default:         legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/exc_ret_check.sv
module exc_ret_check
    import exc_ret_pkg::*;
#(
    parameter int NEXC  = 32,
    parameter int EXC_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              in_handler,
    input  logic [31:0]       ret_value,
    input  logic [EXC_W-1:0]  cur_excnum,
    input  logic [NEXC-1:0]   active_map,
    input  logic [EXC_W-1:0]  stacked_excnum,
    input  logic              sticky_clr,
    output logic              rsp_accept,
    output logic              rsp_fault,
    output logic              rsp_branch,
    output logic              tgt_handler,
    output logic              tgt_psp,
    output logic [NEXC-1:0]   next_active,
    output logic              invpc_sticky
);
    ret_kind_e       kind;
    logic            legal;
    logic [NEXC-1:0] cleared_map;

    exc_ret_decode u_decode (
        .ret_value (ret_value),
        .kind      (kind)
    );

    exc_ret_rules #(.NEXC(NEXC), .EXC_W(EXC_W)) u_rules (
        .kind           (kind),
        .cur_excnum     (cur_excnum),
        .active_map     (active_map),
        .stacked_excnum (stacked_excnum),
        .legal          (legal),
        .cleared_map    (cleared_map)
    );

    resp_state_e     state_q, state_d;
    logic [NEXC-1:0] map_q;
    logic            hnd_q, psp_q;

    always_comb begin
        if (!req_valid)       state_d = ST_IDLE;
        else if (!in_handler) state_d = ST_BRANCH;
        else if (legal)       state_d = ST_ACCEPT;
        else                  state_d = ST_FAULT;
    end

    // State register plus the data captured alongside it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            map_q        <= '0;
            hnd_q        <= 1'b0;
            psp_q        <= 1'b0;
            invpc_sticky <= 1'b0;
        end else begin
            state_q <= state_d;
            map_q   <= (state_d == ST_ACCEPT) ? cleared_map : active_map;
            hnd_q   <= (kind == RK_HANDLER_MAIN);
            psp_q   <= (kind == RK_THREAD_PROC);
            if (state_d == ST_FAULT)  invpc_sticky <= 1'b1;
            else if (sticky_clr)      invpc_sticky <= 1'b0;
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        rsp_accept  = 1'b0;
        rsp_fault   = 1'b0;
        rsp_branch  = 1'b0;
        tgt_handler = 1'b0;
        tgt_psp     = 1'b0;
        next_active = '0;
        unique case (state_q)
            ST_ACCEPT: begin
                rsp_accept  = 1'b1;
                tgt_handler = hnd_q;
                tgt_psp     = psp_q;
                next_active = map_q;
            end
            ST_FAULT: begin
                rsp_fault   = 1'b1;
                next_active = map_q;
            end
            ST_BRANCH: begin
                rsp_branch  = 1'b1;
                next_active = map_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/exc_ret_check_sva.sv
module exc_ret_check_sva #(
    parameter int NEXC  = 32,
    parameter int EXC_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              in_handler,
    input logic [31:0]       ret_value,
    input logic [EXC_W-1:0]  cur_excnum,
    input logic [NEXC-1:0]   active_map,
    input logic [EXC_W-1:0]  stacked_excnum,
    input logic              sticky_clr,
    input logic              rsp_accept,
    input logic              rsp_fault,
    input logic              rsp_branch,
    input logic              tgt_handler,
    input logic              tgt_psp,
    input logic [NEXC-1:0]   next_active,
    input logic              invpc_sticky
);
    assert_one_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_accept, rsp_fault, rsp_branch}));

    assert_quiet_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req_valid) |-> !(rsp_accept || rsp_fault || rsp_branch));

    assert_thread_branch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && !in_handler) |-> rsp_branch && next_active == $past(active_map));

    assert_fault_keeps_map_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> next_active == $past(active_map));

    assert_accept_drops_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_accept |-> $countones(next_active) + 1 == $countones($past(active_map)));

    assert_sticky_on_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> invpc_sticky);

    assert_sticky_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sticky_clr) && !rsp_fault |-> !invpc_sticky);

    assert_reserved_faults_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && in_handler && ret_value == 32'hFFFF_FFF0) |-> rsp_fault);

    assert_handler_target_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_accept && tgt_handler |-> $past(ret_value) == 32'hFFFF_FFF1);

    assert_psp_only_thread_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_psp |-> rsp_accept && !tgt_handler);

    assert_thread_stk_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && in_handler && ret_value == 32'hFFFF_FFF9 && stacked_excnum != '0)
        |-> rsp_fault);

    assert_handler_stk_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && in_handler && ret_value == 32'hFFFF_FFF1 && stacked_excnum == '0)
        |-> rsp_fault);

    assert_inactive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && in_handler && active_map == '0) |-> rsp_fault);

    assert_nested_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && in_handler && $countones(active_map) > 1) |-> !(rsp_accept && !tgt_handler));

    // cur_excnum only matters through the rules above
    logic unused_ok;
    assign unused_ok = ^cur_excnum;
endmodule

bind exc_ret_check exc_ret_check_sva #(.NEXC(NEXC), .EXC_W(EXC_W)) u_sva (.*);

// File: tb/exc_ret_check_bench.sv
`timescale 1ns/1ps
module exc_ret_check_bench;
    localparam int NEXC  = 32;
    localparam int EXC_W = 9;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              in_handler = 1'b0;
    logic [31:0]       ret_value = '0;
    logic [EXC_W-1:0]  cur_excnum = '0;
    logic [NEXC-1:0]   active_map = '0;
    logic [EXC_W-1:0]  stacked_excnum = '0;
    logic              sticky_clr = 1'b0;
    logic              rsp_accept, rsp_fault, rsp_branch, tgt_handler, tgt_psp, invpc_sticky;
    logic [NEXC-1:0]   next_active;

    always #2.5 clk = ~clk;

    exc_ret_check #(.NEXC(NEXC), .EXC_W(EXC_W)) u_exc_ret_check (.*);

    typedef struct {
        logic [5:0]      flags;   // accept, fault, branch, handler, psp, sticky
        logic [NEXC-1:0] nact;
        string           tag;
    } item_t;

    item_t q[$];
    int    n_checks = 0;
    int    n_fails  = 0;
    logic  exp_sticky = 1'b0;
    bit    done = 1'b0;

    task automatic check(input bit ok, input string tag, input string act, input string exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%s expected=%s", tag, act, exp);
        end
    endtask

    // Driver: one cycle of stimulus plus its expected response.
    task automatic step(input bit v, input bit h, input logic [31:0] rv, input int cur,
                        input logic [NEXC-1:0] act, input int stk, input bit clr,
                        input string tag);
        item_t it;
        bit acc, flt, brn, hnd, psp;
        bit own, others, good;
        @(negedge clk);
        req_valid = v; in_handler = h; ret_value = rv;
        cur_excnum = EXC_W'(cur); active_map = act; stacked_excnum = EXC_W'(stk);
        sticky_clr = clr;
        acc = 0; flt = 0; brn = 0; hnd = 0; psp = 0;
        own    = (cur < NEXC) && act[cur % NEXC];
        others = ((cur < NEXC) ? (act & ~(NEXC'(1) << cur)) : act) != '0;
        if (v && !h) brn = 1;
        else if (v) begin
            if (rv == 32'hFFFF_FFF1)      good = own && stk != 0;
            else if (rv == 32'hFFFF_FFF9 || rv == 32'hFFFF_FFFD)
                                          good = own && !others && stk == 0;
            else                          good = 0;
            acc = good; flt = !good;
            hnd = good && rv == 32'hFFFF_FFF1;
            psp = good && rv == 32'hFFFF_FFFD;
        end
        if (flt) exp_sticky = 1'b1;
        else if (clr) exp_sticky = 1'b0;
        it.flags = {acc, flt, brn, hnd, psp, exp_sticky};
        it.nact  = !v ? '0 : (acc ? ((cur < NEXC) ? act & ~(NEXC'(1) << cur) : act) : act);
        it.tag   = tag;
        q.push_back(it);
    endtask

    // Monitor: compares one queued item per cycle, just after the edge.
    always @(posedge clk) begin
        #1;
        if (rst_n && q.size() > 0) begin
            item_t it;
            logic [5:0] got;
            it  = q.pop_front();
            got = {rsp_accept, rsp_fault, rsp_branch, tgt_handler, tgt_psp, invpc_sticky};
            check(got == it.flags, it.tag, $sformatf("flags=%b", got), $sformatf("flags=%b", it.flags));
            check(next_active == it.nact, it.tag, $sformatf("map=%h", next_active),
                  $sformatf("map=%h", it.nact));
        end
    end

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    localparam logic [31:0] H1 = 32'hFFFF_FFF1;
    localparam logic [31:0] T9 = 32'hFFFF_FFF9;
    localparam logic [31:0] TD = 32'hFFFF_FFFD;

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check({rsp_accept, rsp_fault, rsp_branch, invpc_sticky} == 4'b0 && next_active == '0,
              "R10 reset", $sformatf("%b", {rsp_accept, rsp_fault, rsp_branch, invpc_sticky}), "0000");

        step(1, 1, T9, 3, 32'h8, 0, 0, "R1 thread main");
        step(1, 1, TD, 3, 32'h8, 0, 0, "R1 thread proc");
        step(1, 1, H1, 5, 32'h28, 3, 0, "R1 handler main R7");
        step(0, 1, H1, 5, 32'h28, 3, 0, "R10 idle");
        step(1, 1, 32'hFFFF_FFF0, 3, 32'h8, 0, 0, "R2 reserved F0");
        step(1, 1, 32'hFFFF_FFF5, 3, 32'h8, 0, 1, "R2 reserved F5 R9 fault beats clear");
        step(1, 1, 32'hFFFF_FFE9, 3, 32'h8, 0, 0, "R2 reserved E9");
        step(0, 0, '0, 0, '0, 0, 1, "R9 clear");
        step(1, 1, H1, 11, 32'h10, 4, 0, "R3 inactive");
        step(1, 1, T9, 40, 32'h10, 0, 0, "R3 beyond bitmap");
        step(1, 1, T9, 11, 32'h8800, 0, 0, "R4 nested left");
        step(1, 1, H1, 11, 32'h8800, 15, 0, "R11 retry handler");
        step(1, 1, T9, 11, 32'h800, 3, 0, "R5 stacked nonzero");
        step(1, 1, T9, 11, 32'h800, 0, 0, "R11 retry stacked fixed");
        step(1, 1, H1, 11, 32'h8800, 0, 0, "R6 stacked zero");
        step(1, 1, H1, 11, 32'h8800, 15, 0, "R11 retry handler field");
        step(1, 0, T9, 11, 32'h8800, 0, 0, "R8 thread branch");
        step(1, 0, 32'hFFFF_FFF0, 0, 32'h3, 0, 1, "R8 branch with clear R9");
        step(0, 0, '0, 0, '0, 0, 0, "R10 quiet");
        step(0, 0, '0, 0, '0, 0, 0, "R10 quiet");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule